// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This unit holds the program counter of a small 8-bit processor with 4-bit opcodes and decides, one instruction per clock, what the counter becomes next. Decode supplies the opcode, an 8-bit immediate, a 16-bit target address, the sequential next-PC value and a 4-bit flag vector from the ALU. The unit resolves the unconditional jump, the call, the halt and a single conditional jump. For the conditional jump, the low three immediate bits choose one of eight flag tests.

The conditional path selects the new counter one byte at a time. Each byte has its own 8-bit select between the sequential value and the target, and every byte select is steered by the same evaluated condition. A call also produces a one-cycle push request that carries the return address, which is written to a stack outside this unit. A halt freezes the counter until reset. A combinational write-back permit tells the register file whether the current instruction may write a result.

The unit has two named states. **ST_RUN** is entered on reset. **ST_HALT** is entered from ST_RUN on the halt opcode. The transitions are: *reset → ST_RUN*, *ST_RUN → ST_RUN* on every non-halt opcode, *ST_RUN → ST_HALT* on opcode 0xF, and *ST_HALT → ST_HALT* on every opcode until reset.

Top module: `pc_next_unit`

## Requirements
- R1: While reset is held, and on the first sample after it, `pc` is 0x0000 and `taken`, `push_req` and `halted` are all 0.
- R2: For opcode 0xD the test is chosen by imm[2:0], and the flag bits sit at fixed positions: flags[0] = zero, flags[1] = negative, flags[2] = carry, flags[3] = overflow. The tests are: 0 zero set, 1 zero clear, 2 carry set, 3 carry clear, 4 negative set, 5 negative clear, 6 overflow set, 7 overflow clear.
- R3: For opcode 0xD, after the clock edge, `pc` equals `target` and `taken` is 1 when the test holds. When the test fails, `pc` equals `seq_pc` and `taken` is 0. Both bytes of `pc` follow the same decision.
- R4: For opcode 0xD, imm[7:3] has no effect on `pc` or `taken`.
- R5: Opcode 0xC loads `target` into `pc` and sets `taken` to 1 for any flag value.
- R6: Opcode 0xE loads `target` into `pc` and sets `taken`. It raises `push_req` for exactly that one cycle, with `push_addr` equal to the `seq_pc` presented alongside the call.
- R7: Opcode 0xF sets `halted` after the edge and leaves `pc` at its value from before the halt. After that, `pc` and `halted` hold for any later input until reset, and `taken` and `push_req` stay 0.
- R8: Opcodes 0x0 to 0xB load `seq_pc` into `pc`, with `taken` and `push_req` at 0.
- R9: `wb_en` is 1 for opcodes 0x0 to 0xB in ST_RUN. It is 0 for opcodes 0xC to 0xF and at all times while halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 4 | Opcode of the current instruction |
| imm | input | 8 | Immediate; bits [2:0] choose the conditional test |
| target | input | 16 | Jump or call destination |
| seq_pc | input | 16 | Sequential next-PC value |
| flags | input | 4 | Condition flags {V, C, N, Z} |
| pc | output | 16 | Program counter (registered) |
| taken | output | 1 | The last instruction redirected the counter to the target |
| push_req | output | 1 | One-cycle strobe asking for the return address to be pushed |
| push_addr | output | 16 | Return address to push |
| halted | output | 1 | The unit is in ST_HALT |
| wb_en | output | 1 | Combinational write-back permit for the current instruction |

## Verification
The outputs `pc`, `taken`, `push_req`, `push_addr` and `halted` are registered, so each result appears one rising edge after its instruction is applied. `wb_en` is combinational and is valid in the same cycle as its opcode. The bench changes inputs on the falling edge. It reads `wb_en` just before the following rising edge, and it reads the registered outputs at the falling edge after that rising edge, so no check ever straddles an edge. In the halt scenario, several instructions are applied after the halt and the frozen values are checked after each of them.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam logic [3:0] OP_JMP  = 4'hC;
    localparam logic [3:0] OP_JCC  = 4'hD;
    localparam logic [3:0] OP_CALL = 4'hE;
    localparam logic [3:0] OP_HALT = 4'hF;

    // bit positions inside the flag vector
    localparam int FLG_Z = 0;
    localparam int FLG_N = 1;
    localparam int FLG_C = 2;
    localparam int FLG_V = 3;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_e;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import bru_pkg::*;
#(
    parameter int FLAG_W = 4
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [2:0]        sel,
    output logic              hit
);

    logic picked;

    // sel[2:1] names the flag, sel[0] inverts the test
    always_comb begin
        unique case (sel[2:1])
            2'b00:   picked = flags[FLG_Z];
            2'b01:   picked = flags[FLG_C];
            2'b10:   picked = flags[FLG_N];
            default: picked = flags[FLG_V];
        endcase
        hit = picked ^ sel[0];
    end

endmodule

// File: rtl/byte_sel.sv
module byte_sel #(
    parameter int W = 8
) (
    input  logic [W-1:0] when_low,
    input  logic [W-1:0] when_high,
    input  logic         pick,
    output logic [W-1:0] y
);

    assign y = pick ? when_high : when_low;

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import bru_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int IMM_W  = 8,
    parameter int OP_W   = 4,
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    input  logic [IMM_W-1:0]  imm,
    input  logic [PC_W-1:0]   target,
    input  logic [PC_W-1:0]   seq_pc,
    input  logic [FLAG_W-1:0] flags,
    output logic [PC_W-1:0]   pc,
    output logic              taken,
    output logic              push_req,
    output logic [PC_W-1:0]   push_addr,
    output logic              halted,
    output logic              wb_en
);

    localparam int NB = PC_W / 8;

    run_state_e state, state_d;

    logic            cond_hit;
    logic [PC_W-1:0] jcc_pc;
    logic [PC_W-1:0] pc_d;
    logic            taken_d;
    logic            push_d;
    logic            unused_imm;

    assign unused_imm = ^imm[IMM_W-1:3];

    cond_eval #(.FLAG_W(FLAG_W)) u_cond (
        .flags (flags),
        .sel   (imm[2:0]),
        .hit   (cond_hit)
    );

    // byte-wise choice between sequential and target, one shared decision
    for (genvar b = 0; b < NB; b++) begin : g_byte
        byte_sel #(.W(8)) u_sel (
            .when_low  (seq_pc[b*8 +: 8]),
            .when_high (target[b*8 +: 8]),
            .pick      (cond_hit),
            .y         (jcc_pc[b*8 +: 8])
        );
    end

    // next-state and next-output decision
    always_comb begin
        state_d = state;
        pc_d    = pc;
        taken_d = 1'b0;
        push_d  = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (opcode == OP_JMP) begin
                    pc_d    = target;
                    taken_d = 1'b1;
                end else if (opcode == OP_JCC) begin
                    pc_d    = jcc_pc;
                    taken_d = cond_hit;
                end else if (opcode == OP_CALL) begin
                    pc_d    = target;
                    taken_d = 1'b1;
                    push_d  = 1'b1;
                end else if (opcode == OP_HALT) begin
                    state_d = ST_HALT;
                end else begin
                    pc_d = seq_pc;
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc        <= '0;
            taken     <= 1'b0;
            push_req  <= 1'b0;
            push_addr <= '0;
        end else begin
            pc       <= pc_d;
            taken    <= taken_d;
            push_req <= push_d;
            if (push_d) push_addr <= seq_pc;
        end
    end

    assign halted = (state == ST_HALT);
    assign wb_en  = (state == ST_RUN) && (opcode < OP_JMP);

    // R3: a taken redirect lands exactly on the target offered one edge earlier
    a_r3_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> pc == $past(target));

    // R6: a push strobe only follows a call, carrying the sequential value
    a_r6_push_from_call: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> $past(opcode) == OP_CALL);

    a_r6_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> push_addr == $past(seq_pc));

    // R7: halt is sticky and freezes the counter
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r7_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc) && !taken && !push_req));

endmodule

// File: tb/pc_next_unit_bench.sv
`timescale 1ns/100ps
module pc_next_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  opcode;
    logic [7:0]  imm;
    logic [15:0] target;
    logic [15:0] seq_pc;
    logic [3:0]  flags;
    logic [15:0] pc;
    logic        taken;
    logic        push_req;
    logic [15:0] push_addr;
    logic        halted;
    logic        wb_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pc_next_unit u_pc_next_unit (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .imm(imm),
        .target(target), .seq_pc(seq_pc), .flags(flags),
        .pc(pc), .taken(taken), .push_req(push_req), .push_addr(push_addr),
        .halted(halted), .wb_en(wb_en)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic expect_hit(input logic [2:0] s, input logic [3:0] f);
        logic v;
        case (s[2:1])
            2'd0: v = f[0];
            2'd1: v = f[2];
            2'd2: v = f[1];
            default: v = f[3];
        endcase
        return s[0] ? ~v : v;
    endfunction

    // drive at negedge, let one rising edge pass, sample at next negedge
    task automatic step(input logic [3:0] op, input logic [7:0] im,
                        input logic [15:0] tg, input logic [15:0] sq, input logic [3:0] fl);
        opcode = op; imm = im; target = tg; seq_pc = sq; flags = fl;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; opcode = 4'h0; imm = 8'h00; target = 16'h0; seq_pc = 16'h0; flags = 4'h0;
        repeat (2) @(negedge clk);
        chk("R1 pc in reset", pc, 16'h0000);
        chk("R1 halted in reset", {15'd0, halted}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc after reset", pc, 16'h0000);
        chk("R1 taken after reset", {15'd0, taken}, 16'd0);
        chk("R1 push after reset", {15'd0, push_req}, 16'd0);
        chk("R1 halted after reset", {15'd0, halted}, 16'd0);
    endtask

    // R2 R3: every test against every flag pattern
    task automatic t_cond_table();
        for (int s = 0; s < 8; s++) begin
            for (int f = 0; f < 16; f++) begin
                logic h;
                h = expect_hit(3'(s), 4'(f));
                step(4'hD, 8'(s), 16'hA55A, 16'h3C01, 4'(f));
                chk("R2 R3 jcc pc", pc, h ? 16'hA55A : 16'h3C01);
                chk("R2 R3 jcc taken", {15'd0, taken}, {15'd0, h});
            end
        end
    endtask

    // R4: upper immediate bits have no effect
    task automatic t_upper_ignored();
        for (int u = 1; u < 32; u += 5) begin
            step(4'hD, {5'(u), 3'd2}, 16'h1234, 16'h00FF, 4'b0100);
            chk("R4 upper imm, carry set", pc, 16'h1234);
            step(4'hD, {5'(u), 3'd2}, 16'h1234, 16'h00FF, 4'b1011);
            chk("R4 upper imm, carry clear", pc, 16'h00FF);
            chk("R4 upper imm taken", {15'd0, taken}, 16'd0);
        end
    endtask

    task automatic t_jmp();
        step(4'hC, 8'h01, 16'hBEEF, 16'h0002, 4'h0);
        chk("R5 jmp pc", pc, 16'hBEEF);
        chk("R5 jmp taken", {15'd0, taken}, 16'd1);
        step(4'hC, 8'h00, 16'h0F0F, 16'h0004, 4'hF);
        chk("R5 jmp pc any flags", pc, 16'h0F0F);
    endtask

    task automatic t_call();
        step(4'hE, 8'h00, 16'h4000, 16'h2223, 4'h5);
        chk("R6 call pc", pc, 16'h4000);
        chk("R6 call taken", {15'd0, taken}, 16'd1);
        chk("R6 push strobe", {15'd0, push_req}, 16'd1);
        chk("R6 push addr", push_addr, 16'h2223);
        step(4'h1, 8'h00, 16'h9999, 16'h4001, 4'h0);
        chk("R6 push one cycle", {15'd0, push_req}, 16'd0);
        chk("R8 seq pc after call", pc, 16'h4001);
    endtask

    task automatic t_other();
        for (int o = 0; o < 12; o++) begin
            step(4'(o), 8'hFF, 16'hFFFF, 16'(16'h0100 + o), 4'hF);
            chk("R8 seq pc", pc, 16'(16'h0100 + o));
            chk("R8 taken low", {15'd0, taken}, 16'd0);
            chk("R8 push low", {15'd0, push_req}, 16'd0);
        end
    endtask

    task automatic t_wb();
        for (int o = 0; o < 16; o++) begin
            @(negedge clk);
            opcode = 4'(o); imm = 8'h00; seq_pc = pc; target = pc; flags = 4'h0;
            #1;
            chk("R9 wb_en", {15'd0, wb_en}, {15'd0, (o < 12) ? 1'b1 : 1'b0});
            if (o == 15) opcode = 4'h0;
        end
        @(negedge clk);
    endtask

    task automatic t_halt();
        logic [15:0] held;
        step(4'hC, 8'h00, 16'h7A7A, 16'h0001, 4'h0);
        held = pc;
        step(4'hF, 8'h00, 16'h1111, 16'h2222, 4'h0);
        chk("R7 halted set", {15'd0, halted}, 16'd1);
        chk("R7 pc kept at halt", pc, held);
        chk("R7 taken low at halt", {15'd0, taken}, 16'd0);
        step(4'hC, 8'h00, 16'h5555, 16'h6666, 4'h0);
        chk("R7 pc frozen after jmp", pc, held);
        chk("R7 taken frozen", {15'd0, taken}, 16'd0);
        step(4'hE, 8'h00, 16'h5555, 16'h6666, 4'h0);
        chk("R7 no push while halted", {15'd0, push_req}, 16'd0);
        step(4'h2, 8'h00, 16'h5555, 16'h6666, 4'h0);
        chk("R7 pc frozen after alu op", pc, held);
        chk("R7 halted sticky", {15'd0, halted}, 16'd1);
        opcode = 4'h3;
        #1;
        chk("R9 wb_en low while halted", {15'd0, wb_en}, 16'd0);
        do_reset();
        chk("R7 reset leaves halt", {15'd0, halted}, 16'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        opcode = 4'h0; imm = 8'h00; target = 16'h0; seq_pc = 16'h0; flags = 4'h0;
        do_reset();
        t_cond_table();
        t_upper_ignored();
        t_jmp();
        t_call();
        t_other();
        t_wb();
        t_halt();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule